// File: doc/BRIEF.md
# DMA Script Engine Register Bank

This block is the control and status register bank that sits between a host processor and a DMA script engine inside a bus-master storage controller. It stores 96 byte-wide registers. The host reaches them with byte or 32-bit accesses over a valid/ready request channel and gets one response per accepted request on a valid/ready response channel. The host side is big-endian and the storage is little-endian, so 32-bit accesses are byte-reversed at the edge. The script engine has its own write port with byte enables, plus two event pulses: one marks the end of an instruction and one marks a halt.

The bank applies the power-on values and clears the interrupt-pending flag when the host reads it. It flags accesses that fall outside the register space. It also decides when the engine runs. A 32-bit write of the script pointer starts the engine unless manual start is selected. A byte write of the control register loads the run request from its go bit when manual start or single-step is active. In single-step mode the engine is told to execute one instruction per start, and the bank stops it and raises a step interrupt at the end of that instruction.

Back-pressure: a request is accepted on a clock edge where `host_req_valid` and `host_req_ready` are both high. `host_req_ready` is high while the response slot is empty or being drained in the same cycle. A response stays valid, with stable data and error flag, until it is taken with `host_rsp_ready`. Responses come out in request order, one cycle after acceptance. Writes return data zero.

Top module: `dse_script_regs`

## Requirements
- R1: After reset every byte reads zero except offset 0x00=0xC0, 0x0C=0x80, 0x0F=0x02, 0x18=0xFF, 0x19=0xF0, 0x1A=0x01, 0x46=0x60, 0x47=0x0F and 0x4C=0x03. `run_req` and `step_limit` are low, no response is pending and `host_req_ready` is high.
- R2: Only bits [7:0] of `host_req_addr` select the offset. A byte write stores `host_req_wdata[7:0]`. A byte read returns the byte in `host_rsp_data[7:0]` with the upper bits zero.
- R3: A 32-bit write at offset A stores `wdata[31:24]` at A, `[23:16]` at A+1, `[15:8]` at A+2 and `[7:0]` at A+3. A 32-bit read at A returns A in bits [31:24] down to A+3 in bits [7:0].
- R4: A byte access above offset 0x5F, or a 32-bit access above offset 0x5C, returns `host_rsp_err`=1 and data 0, and changes no register.
- R5: A byte read of offset 0x14 returns the current value and clears its bit 0. A 32-bit read covering 0x14 clears nothing.
- R6: An accepted 32-bit write at offset 0x2C sets `run_req` when bit 0 (manual start) of offset 0x38 is 0, and leaves `run_req` unchanged when that bit is 1.
- R7: An accepted byte write of offset 0x3B loads `run_req` from written bit 2 (go) when bit 0 of 0x38 is 1 or written bit 4 (single step) is 1. Otherwise `run_req` is unchanged.
- R8: `step_limit` equals bit 4 of 0x3B. While it is 1, a pulse on `eng_step_done` clears `run_req` and sets bit 3 of 0x0C and bit 0 of 0x14. That set survives a byte read of 0x14 in the same cycle, and the read returns the value from before the set.
- R9: A pulse on `eng_halt` clears `run_req`, unless a host start from R6 or R7 is accepted in the same cycle, in which case the start wins.
- R10: An engine write at byte offset E with enable bit k set stores `eng_wr_data[8k+7:8k]` at E+k. A host write to the same byte in the same cycle wins over it.
- R11: While a response is held (`host_rsp_valid`=1, `host_rsp_ready`=0), `host_req_ready` is 0 and the response data and error flag stay stable. Responses keep request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req_valid | input | 1 | Host request valid |
| host_req_ready | output | 1 | Host request ready |
| host_req_write | input | 1 | 1 = write, 0 = read |
| host_req_wide | input | 1 | 1 = 32-bit access, 0 = byte access |
| host_req_addr | input | HOST_AW | Host address; low 8 bits used |
| host_req_wdata | input | 32 | Write data, big-endian for 32-bit access |
| host_rsp_valid | output | 1 | Response valid |
| host_rsp_ready | input | 1 | Response ready |
| host_rsp_data | output | 32 | Read data (big-endian for 32-bit access) |
| host_rsp_err | output | 1 | Access out of range |
| eng_wr_en | input | 1 | Engine write strobe |
| eng_wr_off | input | ENG_AW | Engine write byte offset |
| eng_wr_be | input | 4 | Engine byte enables, bit k for offset+k |
| eng_wr_data | input | 32 | Engine write data, little-endian lanes |
| eng_step_done | input | 1 | Engine finished one instruction |
| eng_halt | input | 1 | Engine stopped on an interrupt |
| run_req | output | 1 | Run request to the engine |
| step_limit | output | 1 | Execute one instruction per start |

## Verification
Two pairs of functions can fall in the same cycle. In the first, a host byte write and an engine write land on the same byte. The bench drives both on one edge and reads the byte back: the host value must be there, and the engine's other enabled byte must also have landed. In the second, a single-step completion and a clearing byte read of offset 0x14 fall on one edge. The bench checks that the read returns the value from before the set and that a later read still sees bit 0 set.

// File: rtl/dse_pkg.sv
package dse_pkg;

  localparam int LANES = 4;

  localparam int OFF_ENG_STAT = 'h0C;
  localparam int OFF_IRQ_STAT = 'h14;
  localparam int OFF_PTR      = 'h2C;
  localparam int OFF_MODE     = 'h38;
  localparam int OFF_CTRL     = 'h3B;

  localparam int MODE_MANUAL_BIT  = 0;
  localparam int CTRL_GO_BIT      = 2;
  localparam int CTRL_STEP_BIT    = 4;
  localparam int IRQ_PEND_BIT     = 0;
  localparam int ENG_STEP_IRQ_BIT = 3;

  function automatic logic [7:0] reset_byte(input int idx);
    case (idx)
      'h00:    reset_byte = 8'hC0;
      'h0C:    reset_byte = 8'h80;
      'h0F:    reset_byte = 8'h02;
      'h18:    reset_byte = 8'hFF;
      'h19:    reset_byte = 8'hF0;
      'h1A:    reset_byte = 8'h01;
      'h46:    reset_byte = 8'h60;
      'h47:    reset_byte = 8'h0F;
      'h4C:    reset_byte = 8'h03;
      default: reset_byte = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/dse_host_port.sv
module dse_host_port #(
  parameter int HOST_AW = 12,
  parameter int NBYTES  = 96
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic               req_wide,
  input  logic [HOST_AW-1:0] req_addr,
  input  logic [31:0]        req_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [31:0]        rsp_data,
  output logic               rsp_err,
  input  logic [31:0]        rd_lanes,
  output logic [7:0]         acc_off,
  output logic               wr_en,
  output logic               wr_wide,
  output logic [31:0]        wr_lanes,
  output logic               rd_clr
);
  import dse_pkg::*;

  localparam int LAST_BYTE = NBYTES - 1;
  localparam int LAST_WORD = NBYTES - LANES;

  logic        fire;
  logic        in_range;
  logic [31:0] rd_result;
  logic        unused_addr_hi;

  assign acc_off        = req_addr[7:0];
  assign unused_addr_hi = ^req_addr;

  assign in_range  = req_wide ? (int'(acc_off) <= LAST_WORD)
                              : (int'(acc_off) <= LAST_BYTE);
  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;

  assign wr_en   = fire && req_write && in_range;
  assign wr_wide = req_wide;
  assign rd_clr  = fire && !req_write && !req_wide && in_range &&
                   (int'(acc_off) == OFF_IRQ_STAT);

  // Lane k of the store-side vector targets offset+k.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    if (k == 0) begin : g_low
      assign wr_lanes[7:0] = req_wide ? req_wdata[31:24] : req_wdata[7:0];
    end else begin : g_high
      assign wr_lanes[8*k +: 8] = req_wide ? req_wdata[31-8*k -: 8] : 8'h00;
    end
  end

  always_comb begin
    rd_result = '0;
    if (!req_write && in_range) begin
      if (req_wide) begin
        for (int k = 0; k < LANES; k++) begin
          rd_result[31-8*k -: 8] = rd_lanes[8*k +: 8];
        end
      end else begin
        rd_result[7:0] = rd_lanes[7:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_result;
      rsp_err   <= !in_range;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/dse_byte_store.sv
module dse_byte_store #(
  parameter int NBYTES = 96,
  parameter int ENG_AW = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_en,
  input  logic              hw_wide,
  input  logic [7:0]        hw_off,
  input  logic [31:0]       hw_lanes,
  input  logic              rd_clr,
  input  logic              eng_we,
  input  logic [ENG_AW-1:0] eng_off,
  input  logic [3:0]        eng_be,
  input  logic [31:0]       eng_lanes,
  input  logic              step_irq,
  output logic [31:0]       rd_lanes,
  output logic              mode_manual,
  output logic              step_mode
);
  import dse_pkg::*;

  localparam int IW = $clog2(NBYTES);

  logic [8*NBYTES-1:0] flat;

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    localparam logic [8:0] IDX = 9'(i);
    logic [8:0] hd;
    logic [8:0] ed;
    logic       h_hit;
    logic       e_hit;
    logic [7:0] nxt;
    logic [7:0] q;

    assign hd    = IDX - {1'b0, hw_off};
    assign ed    = IDX - 9'(eng_off);
    assign h_hit = hw_en && (hw_wide ? (hd < 9'd4) : (hd == 9'd0));
    assign e_hit = eng_we && (ed < 9'd4) && eng_be[ed[1:0]];

    always_comb begin
      nxt = q;
      if (i == OFF_IRQ_STAT && rd_clr) nxt[IRQ_PEND_BIT] = 1'b0;
      if (e_hit) nxt = eng_lanes[8*ed[1:0] +: 8];
      if (i == OFF_IRQ_STAT && step_irq) nxt[IRQ_PEND_BIT] = 1'b1;
      if (i == OFF_ENG_STAT && step_irq) nxt[ENG_STEP_IRQ_BIT] = 1'b1;
      if (h_hit) nxt = hw_lanes[8*hd[1:0] +: 8];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) q <= reset_byte(i);
      else        q <= nxt;
    end

    assign flat[8*i +: 8] = q;
  end

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      logic [8:0]    idx;
      logic [IW-1:0] sel;
      idx = {1'b0, hw_off} + 9'(k);
      sel = (int'(idx) < NBYTES) ? idx[IW-1:0] : '0;
      rd_lanes[8*k +: 8] = (int'(idx) < NBYTES) ? flat[8*sel +: 8] : 8'h00;
    end
  end

  assign mode_manual = flat[8*OFF_MODE + MODE_MANUAL_BIT];
  assign step_mode   = flat[8*OFF_CTRL + CTRL_STEP_BIT];

endmodule

// File: rtl/dse_run_seq.sv
module dse_run_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic [7:0] ctrl_data,
  input  logic       ptr_wr,
  input  logic       mode_manual,
  input  logic       step_mode,
  input  logic       eng_step_done,
  input  logic       eng_halt,
  output logic       run_req,
  output logic       step_irq
);
  import dse_pkg::*;

  logic ctrl_start;
  logic ptr_start;

  assign ctrl_start = ctrl_wr && (mode_manual || ctrl_data[CTRL_STEP_BIT]);
  assign ptr_start  = ptr_wr && !mode_manual;
  assign step_irq   = eng_step_done && step_mode;

  always_ff @(posedge clk) begin
    if (!rst_n)                     run_req <= 1'b0;
    else if (ctrl_start)            run_req <= ctrl_data[CTRL_GO_BIT];
    else if (ptr_start)             run_req <= 1'b1;
    else if (eng_halt || step_irq)  run_req <= 1'b0;
  end

endmodule

// File: rtl/dse_script_regs.sv
module dse_script_regs #(
  parameter int HOST_AW = 12,
  parameter int NBYTES  = 96,
  parameter int ENG_AW  = $clog2(NBYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_req_valid,
  output logic               host_req_ready,
  input  logic               host_req_write,
  input  logic               host_req_wide,
  input  logic [HOST_AW-1:0] host_req_addr,
  input  logic [31:0]        host_req_wdata,
  output logic               host_rsp_valid,
  input  logic               host_rsp_ready,
  output logic [31:0]        host_rsp_data,
  output logic               host_rsp_err,
  input  logic               eng_wr_en,
  input  logic [ENG_AW-1:0]  eng_wr_off,
  input  logic [3:0]         eng_wr_be,
  input  logic [31:0]        eng_wr_data,
  input  logic               eng_step_done,
  input  logic               eng_halt,
  output logic               run_req,
  output logic               step_limit
);
  import dse_pkg::*;

  logic [31:0] rd_lanes;
  logic [7:0]  acc_off;
  logic        wr_en;
  logic        wr_wide;
  logic [31:0] wr_lanes;
  logic        rd_clr;
  logic        mode_manual;
  logic        step_mode;
  logic        step_irq;
  logic        ctrl_wr;
  logic        ptr_wr;

  dse_host_port #(.HOST_AW(HOST_AW), .NBYTES(NBYTES)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (host_req_valid),
    .req_ready (host_req_ready),
    .req_write (host_req_write),
    .req_wide  (host_req_wide),
    .req_addr  (host_req_addr),
    .req_wdata (host_req_wdata),
    .rsp_valid (host_rsp_valid),
    .rsp_ready (host_rsp_ready),
    .rsp_data  (host_rsp_data),
    .rsp_err   (host_rsp_err),
    .rd_lanes  (rd_lanes),
    .acc_off   (acc_off),
    .wr_en     (wr_en),
    .wr_wide   (wr_wide),
    .wr_lanes  (wr_lanes),
    .rd_clr    (rd_clr)
  );

  dse_byte_store #(.NBYTES(NBYTES), .ENG_AW(ENG_AW)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .hw_en       (wr_en),
    .hw_wide     (wr_wide),
    .hw_off      (acc_off),
    .hw_lanes    (wr_lanes),
    .rd_clr      (rd_clr),
    .eng_we      (eng_wr_en),
    .eng_off     (eng_wr_off),
    .eng_be      (eng_wr_be),
    .eng_lanes   (eng_wr_data),
    .step_irq    (step_irq),
    .rd_lanes    (rd_lanes),
    .mode_manual (mode_manual),
    .step_mode   (step_mode)
  );

  assign ctrl_wr = wr_en && !wr_wide && (int'(acc_off) == OFF_CTRL);
  assign ptr_wr  = wr_en &&  wr_wide && (int'(acc_off) == OFF_PTR);

  dse_run_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctrl_wr       (ctrl_wr),
    .ctrl_data     (wr_lanes[7:0]),
    .ptr_wr        (ptr_wr),
    .mode_manual   (mode_manual),
    .step_mode     (step_mode),
    .eng_step_done (eng_step_done),
    .eng_halt      (eng_halt),
    .run_req       (run_req),
    .step_irq      (step_irq)
  );

  assign step_limit = step_mode;

endmodule

// File: rtl/dse_script_regs_chk.sv
module dse_script_regs_chk #(
  parameter int HOST_AW = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               host_req_valid,
  input logic               host_req_ready,
  input logic               host_req_write,
  input logic               host_req_wide,
  input logic [HOST_AW-1:0] host_req_addr,
  input logic               host_rsp_valid,
  input logic               host_rsp_ready,
  input logic [31:0]        host_rsp_data,
  input logic               host_rsp_err,
  input logic               eng_step_done,
  input logic               eng_halt,
  input logic               run_req,
  input logic               step_limit,
  input logic               mode_manual
);
  logic acc;
  logic acc_wr;
  assign acc    = host_req_valid && host_req_ready;
  assign acc_wr = acc && host_req_write;

  // R11
  stall_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rsp_valid && !host_rsp_ready) |-> !host_req_ready);

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rsp_valid && !host_rsp_ready) |=>
      (host_rsp_valid && $stable(host_rsp_data) && $stable(host_rsp_err)));

  // R4
  range_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (host_req_wide ? (host_req_addr[7:0] > 8'h5C)
                           : (host_req_addr[7:0] > 8'h5F)))
      |=> (host_rsp_valid && host_rsp_err && host_rsp_data == 32'h0));

  // R6
  auto_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && host_req_wide && host_req_addr[7:0] == 8'h2C && !mode_manual)
      |=> run_req);

  // R9
  halt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_halt && !acc_wr) |=> !run_req);

  // R8
  step_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_step_done && step_limit && !acc_wr) |=> !run_req);

endmodule

bind dse_script_regs dse_script_regs_chk #(.HOST_AW(HOST_AW)) u_chk (.*);

// File: tb/dse_script_regs_bench.sv
module dse_script_regs_bench;

  localparam int HOST_AW = 12;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               host_req_valid = 1'b0;
  logic               host_req_ready;
  logic               host_req_write = 1'b0;
  logic               host_req_wide = 1'b0;
  logic [HOST_AW-1:0] host_req_addr = '0;
  logic [31:0]        host_req_wdata = '0;
  logic               host_rsp_valid;
  logic               host_rsp_ready = 1'b1;
  logic [31:0]        host_rsp_data;
  logic               host_rsp_err;
  logic               eng_wr_en = 1'b0;
  logic [6:0]         eng_wr_off = '0;
  logic [3:0]         eng_wr_be = '0;
  logic [31:0]        eng_wr_data = '0;
  logic               eng_step_done = 1'b0;
  logic               eng_halt = 1'b0;
  logic               run_req;
  logic               step_limit;

  always #2 clk = ~clk;

  dse_script_regs #(.HOST_AW(HOST_AW)) u_dse_script_regs (.*);

  typedef struct {
    logic [31:0] data;
    logic        err;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: one compare per response handshake.
  always @(negedge clk) begin
    if (rst_n && host_rsp_valid && host_rsp_ready) begin
      if (q.size() == 0) begin
        check(1'b0, "R11 unexpected response", host_rsp_data, 32'h0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(host_rsp_data == e.data && host_rsp_err == e.err, e.tag,
              {host_rsp_data[30:0], host_rsp_err}, {e.data[30:0], e.err});
      end
    end
  end

  task automatic drive_req(input bit wr, input bit wide, input logic [HOST_AW-1:0] a,
                           input logic [31:0] wd, input logic [31:0] exp,
                           input bit experr, input string tag);
    host_req_valid = 1'b1;
    host_req_write = wr;
    host_req_wide  = wide;
    host_req_addr  = a;
    host_req_wdata = wd;
    q.push_back('{exp, experr, tag});
  endtask

  task automatic acc(input bit wr, input bit wide, input logic [HOST_AW-1:0] a,
                     input logic [31:0] wd, input logic [31:0] exp,
                     input bit experr, input string tag);
    @(negedge clk);
    drive_req(wr, wide, a, wd, exp, experr, tag);
    while (!host_req_ready) @(negedge clk);
    @(negedge clk);
    host_req_valid = 1'b0;
  endtask

  task automatic eng_write(input logic [6:0] off, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    eng_wr_en = 1'b1; eng_wr_off = off; eng_wr_be = be; eng_wr_data = d;
    @(negedge clk);
    eng_wr_en = 1'b0;
  endtask

  task automatic pulse_step();
    @(negedge clk); eng_step_done = 1'b1;
    @(negedge clk); eng_step_done = 1'b0;
  endtask

  task automatic pulse_halt();
    @(negedge clk); eng_halt = 1'b1;
    @(negedge clk); eng_halt = 1'b0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(run_req == 1'b0, "R1 run_req", {31'b0, run_req}, 32'h0);
    check(step_limit == 1'b0, "R1 step_limit", {31'b0, step_limit}, 32'h0);
    check(!host_rsp_valid && host_req_ready, "R1 handshake idle",
          {30'b0, host_rsp_valid, host_req_ready}, 32'h1);
    acc(0, 0, 12'h000, 0, 32'hC0, 0, "R1 0x00");
    acc(0, 0, 12'h00C, 0, 32'h80, 0, "R1 0x0C");
    acc(0, 0, 12'h00F, 0, 32'h02, 0, "R1 0x0F");
    acc(0, 1, 12'h018, 0, 32'hFFF00100, 0, "R1 0x18..0x1B");
    acc(0, 1, 12'h044, 0, 32'h0000600F, 0, "R1 0x44..0x47");
    acc(0, 0, 12'h04C, 0, 32'h03, 0, "R1 0x4C");
    acc(0, 0, 12'h010, 0, 32'h00, 0, "R1 0x10");

    // R2 / R3 byte and wide ordering
    acc(1, 1, 12'h020, 32'h11223344, 0, 0, "R3 wide write");
    acc(0, 0, 12'h020, 0, 32'h11, 0, "R3 lowest offset");
    acc(0, 0, 12'h023, 0, 32'h44, 0, "R3 highest offset");
    acc(0, 1, 12'h020, 0, 32'h11223344, 0, "R3 wide read");
    acc(0, 0, 12'h120, 0, 32'h11, 0, "R2 upper address bits ignored");
    acc(1, 0, 12'h021, 32'hFFFFFF5A, 0, 0, "R2 byte write");
    acc(0, 1, 12'h020, 0, 32'h115A3344, 0, "R2 byte lane only");

    // R4 range errors
    acc(1, 1, 12'h05C, 32'hDEADBEEF, 0, 0, "R4 last wide slot ok");
    acc(0, 1, 12'h05C, 0, 32'hDEADBEEF, 0, "R4 last wide read");
    acc(1, 1, 12'h05D, 32'h01020304, 0, 1, "R4 wide write err");
    acc(0, 0, 12'h05D, 0, 32'hAD, 0, "R4 no change after err");
    acc(0, 0, 12'h060, 0, 32'h0, 1, "R4 byte read err");
    acc(0, 1, 12'h05D, 0, 32'h0, 1, "R4 wide read err");
    acc(1, 0, 12'h05F, 32'h77, 0, 0, "R4 last byte write ok");
    acc(0, 0, 12'h05F, 0, 32'h77, 0, "R4 last byte read");

    // R5 read-to-clear
    eng_write(7'h14, 4'b0001, 32'h00000005);
    acc(0, 0, 12'h014, 0, 32'h05, 0, "R5 first read");
    acc(0, 0, 12'h014, 0, 32'h04, 0, "R5 bit 0 cleared");
    eng_write(7'h14, 4'b0001, 32'h00000005);
    acc(0, 1, 12'h014, 0, 32'h05000000, 0, "R5 wide read");
    acc(0, 0, 12'h014, 0, 32'h05, 0, "R5 wide read did not clear");

    // R6 automatic start, R9 halt
    acc(1, 1, 12'h02C, 32'h00001000, 0, 0, "R6 pointer write");
    check(run_req == 1'b1, "R6 auto start", {31'b0, run_req}, 32'h1);
    pulse_halt();
    check(run_req == 1'b0, "R9 halt stops", {31'b0, run_req}, 32'h0);

    // R6 / R7 manual start
    acc(1, 0, 12'h038, 32'h01, 0, 0, "R7 manual mode on");
    acc(1, 1, 12'h02C, 32'h00002000, 0, 0, "R6 pointer write manual");
    check(run_req == 1'b0, "R6 no auto start in manual", {31'b0, run_req}, 32'h0);
    acc(1, 0, 12'h03B, 32'h04, 0, 0, "R7 go write");
    check(run_req == 1'b1, "R7 manual go", {31'b0, run_req}, 32'h1);
    acc(1, 0, 12'h03B, 32'h00, 0, 0, "R7 go clear");
    check(run_req == 1'b0, "R7 manual go cleared", {31'b0, run_req}, 32'h0);
    acc(1, 0, 12'h038, 32'h00, 0, 0, "R7 manual mode off");
    acc(1, 0, 12'h03B, 32'h04, 0, 0, "R7 go ignored");
    check(run_req == 1'b0, "R7 go ignored outside manual/step", {31'b0, run_req}, 32'h0);

    // R9 host start wins over halt in the same cycle
    @(negedge clk);
    drive_req(1, 1, 12'h02C, 32'h00003000, 0, 0, "R9 start with halt");
    eng_halt = 1'b1;
    @(negedge clk);
    host_req_valid = 1'b0; eng_halt = 1'b0;
    check(run_req == 1'b1, "R9 start wins over halt", {31'b0, run_req}, 32'h1);
    pulse_halt();

    // R8 single step
    acc(1, 0, 12'h03B, 32'h14, 0, 0, "R8 step go");
    check(run_req == 1'b1 && step_limit == 1'b1, "R8 step start",
          {30'b0, run_req, step_limit}, 32'h3);
    pulse_step();
    check(run_req == 1'b0, "R8 step done stops", {31'b0, run_req}, 32'h0);
    acc(0, 0, 12'h00C, 0, 32'h88, 0, "R8 step interrupt flag");
    acc(0, 0, 12'h014, 0, 32'h05, 0, "R8 pending set");
    // Same cycle: step set and clearing read of 0x14
    @(negedge clk);
    drive_req(0, 0, 12'h014, 0, 32'h04, 0, "R8 read in set cycle");
    eng_step_done = 1'b1;
    @(negedge clk);
    host_req_valid = 1'b0; eng_step_done = 1'b0;
    acc(0, 0, 12'h014, 0, 32'h05, 0, "R8 set survives read clear");

    // R10 engine write and host priority
    eng_write(7'h44, 4'b0101, 32'h44332211);
    acc(0, 1, 12'h044, 0, 32'h1100330F, 0, "R10 engine lanes");
    @(negedge clk);
    drive_req(1, 0, 12'h040, 32'h55, 0, 0, "R10 host write in collision");
    eng_wr_en = 1'b1; eng_wr_off = 7'h40; eng_wr_be = 4'b0011; eng_wr_data = 32'h0000BBAA;
    @(negedge clk);
    host_req_valid = 1'b0; eng_wr_en = 1'b0;
    acc(0, 1, 12'h040, 0, 32'h55BB0000, 0, "R10 host wins, engine other lane lands");

    // R11 back-pressure
    @(posedge clk); #1 host_rsp_ready = 1'b0;
    fork
      begin
        acc(0, 0, 12'h000, 0, 32'hC0, 0, "R11 first held");
        acc(0, 0, 12'h00F, 0, 32'h02, 0, "R11 second in order");
      end
      begin
        repeat (4) @(negedge clk);
        check(!host_req_ready && host_rsp_valid, "R11 stall",
              {30'b0, host_req_ready, host_rsp_valid}, 32'h1);
        check(host_rsp_data == 32'hC0, "R11 held data", host_rsp_data, 32'hC0);
        @(posedge clk); #1 host_rsp_ready = 1'b1;
      end
    join

    repeat (4) @(negedge clk);
    check(q.size() == 0, "R11 all responses seen", q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule